// File: doc/BRIEF.md
# Input Capture Unit with Edge Prescaler

This unit watches one external input pin and, when a selected kind of transition arrives, copies the current value of a 16-bit free-running timer into a holding register. It also raises a sticky flag that software clears. The timer is not part of the unit, and a capture never disturbs it. The pin is first passed through a two-stage synchroniser and an edge detector. The detected edges then go through an event prescaler that can count rising edges in groups of four or sixteen.

A 4-bit mode field, loaded through a single-cycle write strobe, selects the behaviour. Code 0100 captures on each falling edge and 0101 on each rising edge. Code 0110 captures on every fourth rising edge and 0111 on every sixteenth. Code 0000 turns the unit off, and any other code counts as a non-capture setting. The prescale count clears only while the unit is out of capture mode, so a change from one ratio to the other keeps the partial count. A sleep input models low power: while it is high, edges are still counted and a qualifying event still raises the flag, but the holding register keeps its old value.

The holding register and the flag are plain level outputs that software reads at any time. They have no handshake and no back-pressure. A newer capture simply replaces an older one.

Top module: `icu_capture`

## Requirements
- R1: With mode 0100, each falling edge on the pin causes a capture, and the prescale count does not change.
- R2: With mode 0101, each rising edge on the pin causes a capture.
- R3: With mode 0110, a capture happens on the 4th rising edge counted since the count was last cleared, and three rising edges alone cause none.
- R4: With mode 0111, a capture happens on the 16th rising edge counted since the count was last cleared, and fifteen alone cause none.
- R5: While reset is low, the mode reads 0000 and the holding register, the flag and the prescale count are all zero.
- R6: With mode 0000 or any code outside 0100 to 0111, pin edges cause no capture and the prescale count is held at zero.
- R7: A pin transition applied before a clock edge causes a capture at the third clock edge. That capture loads the timer value present at that third edge. Two captures therefore measure an interval by 16-bit modular subtraction, and this holds across a timer wrap.
- R8: The flag, once set, stays high until the flag-clear input is sampled high. If a capture and a clear fall in the same cycle, the capture wins and the flag stays high.
- R9: A second capture replaces an unread value in the holding register.
- R10: A write that switches directly from mode 0111 to mode 0110 keeps the prescale count. If ten edges were counted before the switch, the first rising edge after it captures, and the flag this raises can then be cleared.
- R11: While sleep is high, a qualifying event sets the flag but leaves the holding register unchanged, and the prescaler keeps counting the edges that arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | Mode value loaded when mode_wr is high |
| mode_o | output | 4 | Current mode field |
| timer_val | input | 16 | Free-running timer value |
| pin_in | input | 1 | External event input, asynchronous |
| sleep | input | 1 | Low-power indication |
| flag_clr | input | 1 | Clears the capture flag |
| cap_value | output | 16 | Holding register |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A capture setting the flag and software clearing it can land on the same clock edge. The bench provokes this by raising flag_clr in the cycle just before the third edge after a pin rise. At that third edge the synchronised edge turns into a capture. The check passes only if the flag is still high after that edge and then falls after a lone clear. The sleep path is judged in a similar way. The bench mixes sleeping and waking edges within one group of four and expects the capture on the fourth edge overall, which shows that the sleeping edges were counted.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_FALL   = 4'b0100,
    MODE_RISE   = 4'b0101,
    MODE_RISE_A = 4'b0110,
    MODE_RISE_B = 4'b0111
  } icu_mode_e;

  function automatic logic is_capture(input logic [3:0] m);
    return (m[3:2] == 2'b01);
  endfunction

endpackage

// File: rtl/icu_edge_sync.sv
module icu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  // stages 0..STAGES-1 synchronise, stage STAGES holds the previous sample
  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], pin_in};
  end

  assign rise_o =  shreg[LAST-1] & ~shreg[LAST];
  assign fall_o = ~shreg[LAST-1] &  shreg[LAST];
endmodule

// File: rtl/icu_prescaler.sv
module icu_prescaler
  import icu_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int CNT_W = $clog2(DIV_B)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode,
  input  logic             rise,
  input  logic             fall,
  output logic             event_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);

  logic [CNT_W-1:0] cnt;
  logic             counts_rise;

  always_comb begin
    event_o     = 1'b0;
    counts_rise = 1'b1;
    case (mode)
      MODE_FALL:   begin event_o = fall; counts_rise = 1'b0; end
      MODE_RISE:   event_o = rise;
      MODE_RISE_A: event_o = rise && (cnt >= LAST_A);
      MODE_RISE_B: event_o = rise && (cnt >= LAST_B);
      default:     counts_rise = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!is_capture(mode))  cnt <= '0;
    else if (counts_rise && rise) begin
      if (event_o) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/icu_hold.sv
module icu_hold #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          event_i,
  input  logic          sleep,
  input  logic          flag_clr,
  input  logic [TW-1:0] timer_val,
  output logic [TW-1:0] value_o,
  output logic          flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value_o <= '0;
    else if (event_i && !sleep) value_o <= timer_val;
  end

  // a capture in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (event_i)  flag_o <= 1'b1;
    else if (flag_clr) flag_o <= 1'b0;
  end
endmodule

// File: rtl/icu_capture.sv
module icu_capture
  import icu_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int CNT_W       = $clog2(DIV_B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [3:0]    mode_wdata,
  output logic [3:0]    mode_o,
  input  logic [TW-1:0] timer_val,
  input  logic          pin_in,
  input  logic          sleep,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_value,
  output logic          cap_flag
);
  logic [3:0]       mode_q;
  logic             rise, fall, cap_event;
  logic [CNT_W-1:0] presc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_wr) mode_q <= mode_wdata;
  end
  assign mode_o = mode_q;

  icu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .rise_o(rise), .fall_o(fall)
  );

  icu_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .rise(rise), .fall(fall),
    .event_o(cap_event), .cnt_o(presc_cnt)
  );

  icu_hold #(.TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .event_i(cap_event), .sleep(sleep),
    .flag_clr(flag_clr), .timer_val(timer_val),
    .value_o(cap_value), .flag_o(cap_flag)
  );
endmodule

// File: rtl/icu_capture_chk.sv
module icu_capture_chk
  import icu_pkg::*;
#(
  parameter int TW    = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode_q,
  input logic             sleep,
  input logic             flag_clr,
  input logic             flag,
  input logic [TW-1:0]    cap_value,
  input logic [CNT_W-1:0] presc_cnt
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R5: assert (flag == 1'b0 && cap_value == '0 && presc_cnt == '0 && mode_q == 4'b0000);
    end
  end

  assert_fall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_FALL |=> $stable(presc_cnt));

  assert_noncap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_capture(mode_q) |=> (presc_cnt == '0 && $stable(cap_value)));

  assert_update_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> flag);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cap_value));
endmodule

bind icu_capture icu_capture_chk #(.TW(TW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_o), .sleep(sleep),
  .flag_clr(flag_clr), .flag(cap_flag), .cap_value(cap_value),
  .presc_cnt(presc_cnt)
);

// File: tb/icu_capture_bench.sv
`timescale 1ns/1ps
module icu_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_wdata = 4'h0;
  logic [3:0]  mode_o;
  logic [15:0] timer_val = 16'h0;
  logic        pin_in = 1'b0;
  logic        sleep = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_val = 16'h0;

  always #2 clk = ~clk;

  icu_capture u_icu_capture (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_o(mode_o), .timer_val(timer_val), .pin_in(pin_in), .sleep(sleep),
    .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
  );

  // {mode, rising pulses, timer, capture expected}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {4'b0101, 5'd1,  16'h1234, 1'b1},
    {4'b0100, 5'd1,  16'h2345, 1'b1},
    {4'b0110, 5'd3,  16'h3456, 1'b0},
    {4'b0110, 5'd4,  16'h4567, 1'b1},
    {4'b0111, 5'd15, 16'h5678, 1'b0},
    {4'b0111, 5'd16, 16'h6789, 1'b1},
    {4'b0000, 5'd2,  16'h789A, 1'b0},
    {4'b1010, 5'd2,  16'h89AB, 1'b0},
    {4'b0101, 5'd2,  16'h9ABC, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'b0100: return "R1";
      4'b0101: return "R2";
      4'b0110: return "R3";
      4'b0111: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); pin_in = 1'b1;
    repeat (3) @(negedge clk);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    repeat (3) @(negedge clk);
    chk("R5 flag", cap_flag, 0);
    chk("R5 value", cap_value, 0);
    chk("R5 mode", mode_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      write_mode(4'b0000);
      write_mode(v[25:22]);
      clear_flag();
      timer_val = v[16:1];
      for (int p = 0; p < int'(v[21:17]); p++) pulse();
      repeat (2) @(negedge clk);
      if (v[0]) exp_val = v[16:1];
      chk({tag_of(v[25:22]), " flag"}, cap_flag, v[0]);
      chk({tag_of(v[25:22]), " value"}, cap_value, exp_val);
    end

    // R7 latency: mode is 0101 here
    clear_flag();
    timer_val = 16'hAAAA;
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 no flag after two edges", cap_flag, 0);
    @(negedge clk);
    chk("R7 flag at third edge", cap_flag, 1);
    chk("R7 value at third edge", cap_value, 16'hAAAA);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);

    // R8 capture and clear in the same cycle
    clear_flag();
    chk("R8 cleared", cap_flag, 0);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R8 set wins over clear", cap_flag, 1);
    pin_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 flag sticky", cap_flag, 1);
    clear_flag();
    chk("R8 clear alone", cap_flag, 0);

    // R9 overwrite
    timer_val = 16'h1111; pulse();
    timer_val = 16'h2222; pulse();
    chk("R9 overwrite", cap_value, 16'h2222);

    // R7 interval across timer wrap
    timer_val = 16'hFFFE; pulse(); a = cap_value;
    timer_val = 16'h0001; pulse(); b = cap_value;
    chk("R7 wrap interval", 16'(b - a), 16'h0003);

    // R10 partial count survives a ratio change
    write_mode(4'b0000);
    write_mode(4'b0111);
    clear_flag();
    for (int p = 0; p < 10; p++) pulse();
    chk("R10 no capture before switch", cap_flag, 0);
    write_mode(4'b0110);
    timer_val = 16'h3333;
    pulse();
    chk("R10 first edge captures", cap_flag, 1);
    chk("R10 value", cap_value, 16'h3333);
    clear_flag();
    chk("R10 flag clearable", cap_flag, 0);

    // R11 sleep
    write_mode(4'b0000);
    write_mode(4'b0110);
    clear_flag();
    sleep = 1'b1;
    timer_val = 16'h4444;
    repeat (4) pulse();
    chk("R11 flag in sleep", cap_flag, 1);
    chk("R11 value kept in sleep", cap_value, 16'h3333);
    clear_flag();
    repeat (2) pulse();
    sleep = 1'b0;
    timer_val = 16'h5555;
    pulse();
    chk("R11 no early capture", cap_flag, 0);
    pulse();
    chk("R11 sleeping edges counted", cap_flag, 1);
    chk("R11 value after wake", cap_value, 16'h5555);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule